// File: doc/BRIEF.md
# Link Error and Signal Presence Monitor

This block sits behind the word aligner of a serial backplane receiver and inspects each aligned 34-bit received word (two overhead bits plus a 32-bit body) during normal operation. It recognises link-control command words, and checks every one that claims to be an IDLE against the fixed IDLE pattern. Any mismatch is reported as a pulse one word clock long.

In cell mode it also tracks the cell period. The embedded cell clock is a word with overhead bits `11`. It must arrive exactly on the last word of each cell. If a cell clock arrives early or late, the block raises a one-word pulse on a separate cell-clock error output. It raises the same pulse when a link-control word sits on the last position where the cell clock should be.

Both error kinds also set a sticky flag. Resync logic can act on this flag later. The flag is cleared only by reset or by the start of link initialisation.

A per-input activity detector looks at the raw bit samples of each serial input for every word. It drops that input's alive flag for any word period without an edge.

Top module: `link_err_monitor`

## Requirements
- R1: A word is link-control class when its overhead is `00`, its command field `rx_data[20:16]` has its top two bits `00`, and the field is not `00000`. Such a word whose field differs from `00111`, or whose payload `rx_data[15:0]` differs from `16'hAAAA`, drives `rx_err` high for exactly the word clock after it is sampled.
- R2: A correct IDLE word (`00111`, `AAAA`, any value in `rx_data[31:21]`), an alignment word (field `00000`, any payload) and any word with overhead other than `00` leave `rx_err` low.
- R3: A cell clock is a word with overhead `11`. When `cell_mode` is low, `cc_err` stays low and the cell phase is dropped.
- R4: The first cell clock after cell mode is entered, or after `init_start`, sets the cell phase without an error. After that a cell clock is expected every L words, where L is the effective cell length.
- R5: A cell clock that arrives at a position other than the last word of the cell drives `cc_err` high for one word clock and restarts the cell phase from that word.
- R6: A link-control class word on the last position of a phased cell drives `cc_err` high for one word clock. A flow-control or data word (overhead `01` or `10`) on that position does not.
- R7: A `cell_len` value below 13 is treated as 13. Values of 13 or more are used as given.
- R8: `err_hold` is set on the same clock as any `rx_err` or `cc_err` pulse and stays set until reset or `init_start`.
- R9: A clock with `init_start` high clears `err_hold`, even if an error is found on that clock, and drops the cell phase.
- R10: `alive[i]` is high for the word clock after a word whose samples `rx_smp[i*34 +: 34]` contain at least one pair of adjacent differing bits. Otherwise it is low.
- R11: While reset is held, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| init_start | input | 1 | Link initialisation starting; clears sticky error and cell phase |
| cell_mode | input | 1 | Enables the cell-clock timing check |
| cell_len | input | LEN_W | Cell length in words (minimum 13 applied) |
| rx_ovh | input | 2 | Overhead bits of the aligned received word |
| rx_data | input | 32 | Body of the aligned received word |
| rx_smp | input | NUM_IN*34 | Raw bit samples for each serial input during one word |
| rx_err | output | 1 | One-word pulse on an IDLE pattern error |
| cc_err | output | 1 | One-word pulse on a cell-clock timing error |
| err_hold | output | 1 | Sticky copy of both error kinds |
| alive | output | NUM_IN | Per-input edge activity seen in the last word |

## Verification
Each output is one register stage behind its inputs. A word presented before clock edge k therefore shows its `rx_err`, `cc_err`, `err_hold` and `alive` result just after edge k. The bench drives each word on the falling edge and samples all four outputs 1 ns after the next rising edge, then compares them with a reference model. That model steps its own cell position and sticky state once per word. Cell phasing depends on history, so the directed cell sequences count words from a known cell clock. Each of those sequences checks the single word clock where the error is due, and also checks that the next word leaves the output low again.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;

    localparam int DATA_W  = 32;
    localparam int OVH_W   = 2;
    localparam int SER_W   = DATA_W + OVH_W;
    localparam int CMD_LSB = 16;
    localparam int CMD_W   = 5;
    localparam int PAY_W   = 16;

    typedef enum logic [OVH_W-1:0] {
        OVH_CMD  = 2'b00,
        OVH_FC_A = 2'b01,
        OVH_FC_B = 2'b10,
        OVH_MARK = 2'b11
    } ovh_e;

    typedef struct packed {
        ovh_e                ovh;
        logic [CMD_W-1:0]    cmd;
        logic [PAY_W-1:0]    pay;
    } lc_word_t;

    localparam logic [CMD_W-1:0] CMD_IDLE  = 5'b00111;
    localparam logic [CMD_W-1:0] CMD_ALIGN = 5'b00000;
    localparam logic [PAY_W-1:0] IDLE_PAY  = 16'hAAAA;

    function automatic logic is_link_ctl(lc_word_t w);
        return (w.ovh == OVH_CMD) && (w.cmd[CMD_W-1 -: 2] == 2'b00) && (w.cmd != CMD_ALIGN);
    endfunction

    function automatic logic idle_matches(lc_word_t w);
        return (w.cmd == CMD_IDLE) && (w.pay == IDLE_PAY);
    endfunction

    function automatic logic has_edge(logic [SER_W-1:0] s);
        return |(s[SER_W-1:1] ^ s[SER_W-2:0]);
    endfunction

endpackage

// File: rtl/lnkmon_idle_chk.sv
module lnkmon_idle_chk
    import lnkmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lc_word_t word,
    output logic     lc_class,
    output logic     err_now,
    output logic     err_pulse
);

    always_comb begin
        lc_class = is_link_ctl(word);
        err_now  = lc_class && !idle_matches(word);
    end

    always_ff @(posedge clk) begin
        if (rst) err_pulse <= 1'b0;
        else     err_pulse <= err_now;
    end

endmodule

// File: rtl/lnkmon_cell_chk.sv
module lnkmon_cell_chk
    import lnkmon_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int MIN_CELL = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_start,
    input  logic             cell_mode,
    input  logic [LEN_W-1:0] cell_len,
    input  ovh_e             ovh,
    input  logic             lc_class,
    output logic             err_now,
    output logic             err_pulse
);

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_CELL);
    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

    logic             phased;
    logic [LEN_W-1:0] pos;
    logic [LEN_W-1:0] eff_len;
    logic             at_last;
    logic             mark;

    always_comb begin
        eff_len = (cell_len < MIN_L) ? MIN_L : cell_len;
        at_last = phased && (pos >= eff_len - ONE_L);
        mark    = (ovh == OVH_MARK);
        err_now = cell_mode && phased &&
                  ((mark && !at_last) || (at_last && lc_class));
    end

    always_ff @(posedge clk) begin
        if (rst || init_start || !cell_mode) begin
            phased <= 1'b0;
            pos    <= '0;
        end else if (mark) begin
            phased <= 1'b1;
            pos    <= '0;
        end else if (phased) begin
            pos    <= at_last ? '0 : pos + ONE_L;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_pulse <= 1'b0;
        else     err_pulse <= err_now;
    end

endmodule

// File: rtl/lnkmon_activity.sv
module lnkmon_activity
    import lnkmon_pkg::*;
#(
    parameter int NUM_IN = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_IN*SER_W-1:0] smp,
    output logic [NUM_IN-1:0]       alive
);

    for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) alive[g] <= 1'b0;
            else     alive[g] <= has_edge(smp[g*SER_W +: SER_W]);
        end
    end

endmodule

// File: rtl/link_err_monitor.sv
module link_err_monitor
    import lnkmon_pkg::*;
#(
    parameter int NUM_IN   = 2,
    parameter int LEN_W    = 8,
    parameter int MIN_CELL = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    init_start,
    input  logic                    cell_mode,
    input  logic [LEN_W-1:0]        cell_len,
    input  logic [OVH_W-1:0]        rx_ovh,
    input  logic [DATA_W-1:0]       rx_data,
    input  logic [NUM_IN*SER_W-1:0] rx_smp,
    output logic                    rx_err,
    output logic                    cc_err,
    output logic                    err_hold,
    output logic [NUM_IN-1:0]       alive
);

    lc_word_t word;
    logic     lc_class;
    logic     idle_err_now;
    logic     cell_err_now;
    logic     unused_hi;

    always_comb begin
        word.ovh = ovh_e'(rx_ovh);
        word.cmd = rx_data[CMD_LSB +: CMD_W];
        word.pay = rx_data[PAY_W-1:0];
    end

    assign unused_hi = ^rx_data[DATA_W-1:CMD_LSB+CMD_W];

    lnkmon_idle_chk u_idle (
        .clk       (clk),
        .rst       (rst),
        .word      (word),
        .lc_class  (lc_class),
        .err_now   (idle_err_now),
        .err_pulse (rx_err)
    );

    lnkmon_cell_chk #(
        .LEN_W    (LEN_W),
        .MIN_CELL (MIN_CELL)
    ) u_cell (
        .clk        (clk),
        .rst        (rst),
        .init_start (init_start),
        .cell_mode  (cell_mode),
        .cell_len   (cell_len),
        .ovh        (word.ovh),
        .lc_class   (lc_class),
        .err_now    (cell_err_now),
        .err_pulse  (cc_err)
    );

    lnkmon_activity #(
        .NUM_IN (NUM_IN)
    ) u_act (
        .clk   (clk),
        .rst   (rst),
        .smp   (rx_smp),
        .alive (alive)
    );

    always_ff @(posedge clk) begin
        if (rst || init_start) err_hold <= 1'b0;
        else if (idle_err_now || cell_err_now) err_hold <= 1'b1;
    end

endmodule

// File: rtl/link_err_monitor_chk.sv
module link_err_monitor_chk
    import lnkmon_pkg::*;
#(
    parameter int NUM_IN   = 2,
    parameter int LEN_W    = 8,
    parameter int MIN_CELL = 13
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    init_start,
    input logic                    cell_mode,
    input logic [LEN_W-1:0]        cell_len,
    input logic [OVH_W-1:0]        rx_ovh,
    input logic [DATA_W-1:0]       rx_data,
    input logic [NUM_IN*SER_W-1:0] rx_smp,
    input logic                    rx_err,
    input logic                    cc_err,
    input logic                    err_hold,
    input logic [NUM_IN-1:0]       alive
);

    logic unused_chk;
    assign unused_chk = ^{cell_len, rx_data};

    // R1: an IDLE error can only follow a command word
    p_rxerr_cmd_r1: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> ($past(rx_ovh) == 2'b00));

    // R2: a correct IDLE never raises an error
    p_idle_ok_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_ovh) == 2'b00 && $past(rx_data[20:0]) == {5'b00111, 16'hAAAA}) |-> !rx_err);

    // R3: no cell-clock error outside cell mode
    p_ccerr_mode_r3: assert property (@(posedge clk) disable iff (rst)
        cc_err |-> $past(cell_mode));

    // R8: every pulse is reflected in the sticky flag
    p_hold_set_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_err || cc_err) && !$past(init_start) |-> err_hold);

    // R8: sticky flag stays set without init
    p_hold_keep_r8: assert property (@(posedge clk) disable iff (rst)
        $past(err_hold) && !$past(init_start) |-> err_hold);

    // R9: init clears the sticky flag
    p_init_clr_r9: assert property (@(posedge clk) disable iff (rst)
        $past(init_start) |-> !err_hold);

    // R10: a flat word on input 0 means not alive
    p_flat_dead_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_smp[SER_W-1:0]) == '0) |-> !alive[0]);

endmodule

bind link_err_monitor link_err_monitor_chk #(
    .NUM_IN   (NUM_IN),
    .LEN_W    (LEN_W),
    .MIN_CELL (MIN_CELL)
) u_link_err_monitor_chk (
    .clk        (clk),
    .rst        (rst),
    .init_start (init_start),
    .cell_mode  (cell_mode),
    .cell_len   (cell_len),
    .rx_ovh     (rx_ovh),
    .rx_data    (rx_data),
    .rx_smp     (rx_smp),
    .rx_err     (rx_err),
    .cc_err     (cc_err),
    .err_hold   (err_hold),
    .alive      (alive)
);

// File: tb/link_err_monitor_bench.sv
module link_err_monitor_bench;

    localparam int NUM_IN = 2;
    localparam int LEN_W  = 8;
    localparam int SW     = 34;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              init_start = 1'b0;
    logic              cell_mode = 1'b0;
    logic [LEN_W-1:0]  cell_len = 8'd13;
    logic [1:0]        rx_ovh = 2'b00;
    logic [31:0]       rx_data = 32'h0;
    logic [NUM_IN*SW-1:0] rx_smp = '0;
    logic              rx_err, cc_err, err_hold;
    logic [NUM_IN-1:0] alive;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // reference model state
    bit       m_phased = 0;
    int       m_pos    = 0;
    bit       m_hold   = 0;

    always #4 clk = ~clk;

    link_err_monitor #(.NUM_IN(NUM_IN), .LEN_W(LEN_W), .MIN_CELL(13)) u_link_err_monitor (
        .clk(clk), .rst(rst), .init_start(init_start), .cell_mode(cell_mode),
        .cell_len(cell_len), .rx_ovh(rx_ovh), .rx_data(rx_data), .rx_smp(rx_smp),
        .rx_err(rx_err), .cc_err(cc_err), .err_hold(err_hold), .alive(alive));

    function automatic bit f_lc(logic [1:0] o, logic [31:0] d);
        return (o == 2'b00) && (d[20:19] == 2'b00) && (d[20:16] != 5'b00000);
    endfunction

    function automatic bit f_idle_bad(logic [1:0] o, logic [31:0] d);
        return f_lc(o, d) && ((d[20:16] != 5'b00111) || (d[15:0] != 16'hAAAA));
    endfunction

    function automatic bit f_edge(logic [SW-1:0] s);
        for (int i = 0; i < SW - 1; i++) if (s[i] != s[i+1]) return 1;
        return 0;
    endfunction

    function automatic int f_len(logic [LEN_W-1:0] l);
        return (l < 13) ? 13 : int'(l);
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // one word: drive on falling edge, sample 1 ns after the consuming rising edge
    task automatic step(input logic [1:0] o, input logic [31:0] d,
                        input logic [SW-1:0] s0, input logic [SW-1:0] s1, input logic ini);
        bit e_rx, e_cc, last, mark;
        logic [1:0] e_al;
        @(negedge clk);
        rx_ovh = o; rx_data = d; rx_smp = {s1, s0}; init_start = ini;
        last = m_phased && (m_pos >= f_len(cell_len) - 1);
        mark = (o == 2'b11);
        e_rx = f_idle_bad(o, d);
        e_cc = cell_mode && m_phased && ((mark && !last) || (last && f_lc(o, d)));
        e_al = {f_edge(s1), f_edge(s0)};
        if (ini || !cell_mode) begin m_phased = 0; m_pos = 0; end
        else if (mark) begin m_phased = 1; m_pos = 0; end
        else if (m_phased) m_pos = last ? 0 : m_pos + 1;
        m_hold = ini ? 0 : (m_hold | e_rx | e_cc);
        @(posedge clk); #1;
        chk("R1/R2 rx_err", rx_err, e_rx);
        chk("R4/R5/R6 cc_err", cc_err, e_cc);
        chk("R8/R9 err_hold", err_hold, m_hold);
        chk("R10 alive0", alive[0], e_al[0]);
        chk("R10 alive1", alive[1], e_al[1]);
    endtask

    localparam logic [31:0] GOOD_IDLE = {11'h5A3, 5'b00111, 16'hAAAA};
    localparam logic [SW-1:0] BUSY = 34'h2_5555_5555;

    task automatic rand_word(output logic [1:0] o, output logic [31:0] d);
        int k = $urandom % 7;
        d = $urandom;
        case (k)
            0, 1, 2: begin o = 2'b00; d[20:0] = {5'b00111, 16'hAAAA}; end
            3: begin o = 2'b00; d[20:16] = 5'b00111; d[15:0] = 16'hAAAA ^ (16'h1 << ($urandom % 16)); end
            4: begin o = 2'b00; d[20:16] = {2'b00, 3'($urandom % 6 + 1)}; if (d[18:16] == 3'b111) d[16] = 1'b0; end
            5: begin o = 2'b00; d[20:16] = 5'b00000; end
            default: o = 2'b01 + 2'($urandom % 2);
        endcase
    endtask

    task automatic rand_smp(output logic [SW-1:0] s);
        case ($urandom % 4)
            0: s = '0;
            1: s = '1;
            2: s = {SW{1'b1}} >> ($urandom % SW);
            default: s = {$urandom, 2'($urandom)};
        endcase
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [1:0] o; logic [31:0] d; logic [SW-1:0] s0, s1;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1;
        chk("R11 rx_err reset", rx_err, 1'b0);
        chk("R11 cc_err reset", cc_err, 1'b0);
        chk("R11 err_hold reset", err_hold, 1'b0);
        chk("R11 alive reset", |alive, 1'b0);
        @(negedge clk); rst = 1'b0;

        // IDLE pattern checks
        step(2'b00, GOOD_IDLE, BUSY, BUSY, 0);            chk("R2 good idle", rx_err, 0);
        step(2'b00, 32'h0007AAAB, BUSY, BUSY, 0);         chk("R1 bad payload", rx_err, 1);
        step(2'b00, 32'h0006AAAA, BUSY, BUSY, 0);         chk("R1 bad command", rx_err, 1);
        step(2'b00, 32'h00001234, BUSY, BUSY, 0);         chk("R2 align word", rx_err, 0);
        step(2'b01, 32'h00061234, BUSY, BUSY, 0);         chk("R2 other overhead", rx_err, 0);
        step(2'b00, 32'hFFE7AAAA, BUSY, BUSY, 0);         chk("R2 upper bits ignored", rx_err, 0);
        chk("R8 sticky kept", err_hold, 1);
        step(2'b00, 32'h0006AAAA, BUSY, BUSY, 1);         chk("R9 init clears despite error", err_hold, 0);
        chk("R1 pulse with init", rx_err, 1);

        // alive
        step(2'b00, GOOD_IDLE, '0, '1, 0);                chk("R10 flat dead", |alive, 0);
        step(2'b00, GOOD_IDLE, 34'h1, 34'h2_0000_0000, 0); chk("R10 single edge", &alive, 1);

        // cell timing with short length programmed
        cell_mode = 1; cell_len = 8'd5;
        step(2'b11, 32'h0, BUSY, BUSY, 0);                chk("R4 first cell clock", cc_err, 0);
        for (int i = 0; i < 12; i++) step(2'b00, GOOD_IDLE, BUSY, BUSY, 0);
        step(2'b11, 32'h0, BUSY, BUSY, 0);                chk("R7 length 13 applied", cc_err, 0);
        step(2'b11, 32'h0, BUSY, BUSY, 0);                chk("R5 early cell clock", cc_err, 1);
        for (int i = 0; i < 12; i++) step(2'b01, 32'h1, BUSY, BUSY, 0);
        chk("R5 pulse ends", cc_err, 0);
        step(2'b00, GOOD_IDLE, BUSY, BUSY, 0);            chk("R6 idle at cell end", cc_err, 1);
        for (int i = 0; i < 12; i++) step(2'b10, 32'h2, BUSY, BUSY, 0);
        step(2'b01, 32'h3, BUSY, BUSY, 0);                chk("R6 data at cell end", cc_err, 0);
        step(2'b00, GOOD_IDLE, BUSY, BUSY, 1);            chk("R9 init clears", err_hold, 0);
        step(2'b11, 32'h0, BUSY, BUSY, 0);                chk("R9 phase dropped", cc_err, 0);
        cell_mode = 0;
        step(2'b11, 32'h0, BUSY, BUSY, 0);                chk("R3 off mode", cc_err, 0);
        step(2'b11, 32'h0, BUSY, BUSY, 0);                chk("R3 off mode again", cc_err, 0);

        // random traffic
        for (int blk = 0; blk < 12; blk++) begin
            cell_mode = blk[0];
            cell_len  = 8'($urandom % 16 + 6);
            for (int w = 0; w < 250; w++) begin
                rand_word(o, d);
                if (cell_mode) begin
                    if (m_phased && m_pos >= f_len(cell_len) - 1) begin
                        if ($urandom % 100 < 85) o = 2'b11;
                    end else if (!m_phased || $urandom % 100 < 3) begin
                        if (!m_phased || $urandom % 2 == 0) o = 2'b11;
                    end
                end else if ($urandom % 10 == 0) o = 2'b11;
                rand_smp(s0); rand_smp(s1);
                step(o, d, s0, s1, ($urandom % 200) == 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule